// File: doc/BRIEF.md
# DMA Stream Address Sequencer

This block is the control core of a single DMA stream. Software programs a configuration word, an item count, a peripheral base address and two memory base addresses through a simple register port, then sets the run bit. For every item the block presents a source address, a destination address and the element size on each side. An external data mover performs the item and answers with a one-cycle done strobe. The FIFO, burst splitting, bus protocol and interrupt flag storage live elsewhere.

The stream can run in three ways. A normal run stops by itself after the last item. A circular run reloads its count and addresses and keeps going. A double-buffer run alternates between the two memory bases at every period boundary. It reports which base is in use, so software can refill the idle one while the stream is running. Each period boundary raises a one-cycle completion pulse. When software clears the run bit, the stream finishes the item in flight before it reports itself stopped.

Top module: `dma_stream_seq`

## Requirements
- R1: After reset, stream_en, item_req and tc_pulse are 0, and reads of the configuration (select 0) and the count (select 1) return 0.
- R2: The configuration word holds the transfer direction in bits 7:6, the peripheral size in bits 12:11 and the memory size in bits 14:13. For direction 00 (peripheral to memory) the source is the peripheral pointer and the destination is the memory pointer. Direction 01 (memory to peripheral) swaps them. src_size and dst_size carry the size code of their side: 0 byte, 1 halfword, 2 word, and 3 behaves as word.
- R3: Bit 9 enables peripheral increment and bit 10 enables memory increment. An enabled pointer advances by 1, 2 or 4 bytes, according to its side's size, after each item_done. A pointer with increment disabled stays fixed.
- R4: Writing the configuration with bit 0 set starts the stream while it is idle. Each item_done decrements the live count (select 1). When the count reaches zero in normal mode, tc_pulse is high for exactly the one cycle after that item_done, and stream_en is 0 in that same cycle.
- R5: When circular mode (bit 8) is set, the end of a period reloads the live count from its programmed value and returns both pointers to their bases. tc_pulse still fires, and stream_en stays 1.
- R6: Double-buffer mode (bit 18) implies circular reload. At each period end it toggles the current-target bit (bit 19, also on cur_target), and the memory pointer restarts from the base of the new target: select 3 for target 0, select 4 for target 1. The value of bit 19 when the stream starts picks the first target.
- R7: While stream_en is 1, writes to the configuration, the count, the peripheral base and the active memory base are ignored. In double-buffer mode, a write to the idle memory base is accepted.
- R8: A configuration write with bit 0 clear while running leaves stream_en and item_req at 1 until the next item_done. In the cycle after that item_done, both read 0.
- R9: Select 5 reads the remaining byte count, which is the live count shifted left by the peripheral size code.
- R10: In memory-to-memory mode (direction 10), the source is the peripheral pointer and the destination is the memory pointer started from base 0. The double-buffer and target bits have no effect in this mode.
- R11: A start request while the programmed count is 0 is ignored, and the stream stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select: 0 config, 1 count, 2 peripheral base, 3 memory base 0, 4 memory base 1 |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Read select: as for writes, plus 5 for remaining bytes |
| rd_data | output | 32 | Combinational read data |
| item_req | output | 1 | An item is requested from the mover |
| item_done | input | 1 | The mover finished the current item |
| src_addr | output | AW | Source address of the current item |
| dst_addr | output | AW | Destination address of the current item |
| src_size | output | 2 | Source element size code |
| dst_size | output | 2 | Destination element size code |
| tc_pulse | output | 1 | One-cycle period or transfer completion event |
| cur_target | output | 1 | Current memory target in double-buffer mode |
| stream_en | output | 1 | Stream running, including a pending stop |

## Verification
Every register write and every item_done is captured on one rising edge. The pointers, the live count, stream_en, cur_target and tc_pulse all show the result in the cycle that follows that edge. The bench drives inputs on falling edges and samples on the next falling edge, one register stage after the stimulus. rd_data is combinational, so it is read a short delay after rd_sel changes within the same low phase. tc_pulse is checked in the cycle after the last item_done, and again one cycle later to confirm that it has dropped.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int CFG_EN   = 0;
  localparam int CFG_DIR  = 6;
  localparam int CFG_CIRC = 8;
  localparam int CFG_PINC = 9;
  localparam int CFG_MINC = 10;
  localparam int CFG_PSZ  = 11;
  localparam int CFG_MSZ  = 13;
  localparam int CFG_DBM  = 18;
  localparam int CFG_CT   = 19;

  localparam logic [2:0] SEL_CFG   = 3'd0;
  localparam logic [2:0] SEL_CNT   = 3'd1;
  localparam logic [2:0] SEL_PADDR = 3'd2;
  localparam logic [2:0] SEL_MEM0  = 3'd3;
  localparam logic [2:0] SEL_MEM1  = 3'd4;
  localparam logic [2:0] SEL_LEFT  = 3'd5;

  typedef enum logic [1:0] {
    XFER_P2M = 2'b00,
    XFER_M2P = 2'b01,
    XFER_M2M = 2'b10,
    XFER_RSV = 2'b11
  } xfer_dir_e;

  // Element size code to byte step; the reserved code behaves as a word.
  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Bytes still to move for a given item count and peripheral size code.
  function automatic logic [31:0] bytes_left(input logic [31:0] cnt,
                                             input logic [1:0] code);
    return cnt << code;
  endfunction
endpackage

// File: rtl/dma_seq_basereg.sv
module dma_seq_basereg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/dma_seq_ptr.sv
module dma_seq_ptr
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic [1:0]    size_code,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] step_bytes;
  assign step_bytes = AW'(size_to_bytes(size_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (load)  ptr <= load_val;
    else if (adv)   ptr <= ptr + step_bytes;
  end

  // R3: with neither a reload nor an advance, the pointer holds its value
  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(ptr));
endmodule

// File: rtl/dma_seq_counter.sv
module dma_seq_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_prog,
  input  logic [CW-1:0] wr_val,
  input  logic          start,
  input  logic          step,
  input  logic          circ,
  input  logic          running,
  output logic [CW-1:0] prog,
  output logic [CW-1:0] live,
  output logic          last
);
  assign last = (live == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog <= '0;
      live <= '0;
    end else if (wr_prog) begin
      prog <= wr_val;
      live <= wr_val;
    end else if (start) begin
      live <= prog;
    end else if (step) begin
      if (last) live <= circ ? prog : '0;
      else      live <= live - CW'(1);
    end
  end

  // R4: a running stream always has items left
  assert_live_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (live != '0));
  // R5: a reload never yields more items than were programmed
  assert_live_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (live <= prog));
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop_req,
  input  logic step,
  input  logic last,
  input  logic circ_eff,
  input  logic dbm_eff,
  input  logic tgt_load,
  input  logic tgt_val,
  output logic en_q,
  output logic tc_q,
  output logic target_q
);
  logic stop_pend;
  logic period_end;

  assign period_end = step && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      tc_q      <= 1'b0;
      stop_pend <= 1'b0;
      target_q  <= 1'b0;
    end else begin
      tc_q <= period_end;
      if (start) begin
        en_q      <= 1'b1;
        stop_pend <= 1'b0;
      end else if (step && (stop_pend || (last && !circ_eff))) begin
        en_q      <= 1'b0;
        stop_pend <= 1'b0;
      end else if (stop_req) begin
        stop_pend <= 1'b1;
      end
      if (tgt_load)                  target_q <= tgt_val;
      else if (period_end && dbm_eff) target_q <= ~target_q;
    end
  end

  // R8: the stream only stops at an item boundary
  assert_stop_on_item_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> $past(step));
  // R6: while running, the target only changes at a period end
  assert_target_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && (target_q != $past(target_q))) |-> $past(period_end));
  // R4: a completion pulse follows an accepted last item
  assert_tc_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> $past(en_q));
endmodule

// File: rtl/dma_stream_seq.sv
module dma_stream_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic [2:0]    rd_sel,
  output logic [31:0]   rd_data,
  output logic          item_req,
  input  logic          item_done,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [1:0]    src_size,
  output logic [1:0]    dst_size,
  output logic          tc_pulse,
  output logic          cur_target,
  output logic          stream_en
);
  localparam int NBASE  = 3;
  localparam int B_PER  = 0;
  localparam int B_MEM0 = 1;
  localparam int B_MEM1 = 2;

  logic [31:0]   cfg_q;
  logic [AW-1:0] base_q [NBASE];
  logic [NBASE-1:0] base_we;
  logic [CW-1:0] cnt_prog, cnt_live;
  logic          cnt_last;
  logic          en_q, tc_q, target_q;
  logic [AW-1:0] per_ptr, mem_ptr;

  // configuration decode
  xfer_dir_e dir;
  logic [1:0] psz, msz;
  logic pinc, minc, dbm_eff, circ_eff;
  assign dir      = xfer_dir_e'(cfg_q[CFG_DIR +: 2]);
  assign psz      = cfg_q[CFG_PSZ +: 2];
  assign msz      = cfg_q[CFG_MSZ +: 2];
  assign pinc     = cfg_q[CFG_PINC];
  assign minc     = cfg_q[CFG_MINC];
  assign dbm_eff  = cfg_q[CFG_DBM] && (dir != XFER_M2M);
  assign circ_eff = cfg_q[CFG_CIRC] || dbm_eff;

  // write acceptance events
  logic idle, wr_cfg, cfg_accept, start, stop_req, cnt_accept;
  logic new_dbm, start_target;
  assign idle       = !en_q;
  assign wr_cfg     = wr_en && (wr_sel == SEL_CFG);
  assign cfg_accept = wr_cfg && idle;
  assign start      = cfg_accept && wr_data[CFG_EN] && (cnt_prog != '0);
  assign stop_req   = wr_cfg && en_q && !wr_data[CFG_EN];
  assign cnt_accept = wr_en && (wr_sel == SEL_CNT) && idle;
  assign new_dbm    = wr_data[CFG_DBM] && (wr_data[CFG_DIR +: 2] != 2'b10);
  assign start_target = new_dbm && wr_data[CFG_CT];

  assign base_we[B_PER]  = wr_en && (wr_sel == SEL_PADDR) && idle;
  assign base_we[B_MEM0] = wr_en && (wr_sel == SEL_MEM0) &&
                           (idle || (dbm_eff && target_q));
  assign base_we[B_MEM1] = wr_en && (wr_sel == SEL_MEM1) &&
                           (idle || (dbm_eff && !target_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_q <= '0;
    else if (cfg_accept) cfg_q <= wr_data;
  end

  for (genvar gi = 0; gi < NBASE; gi++) begin : g_base
    dma_seq_basereg #(.AW(AW)) u_base (
      .clk(clk), .rst_n(rst_n), .we(base_we[gi]),
      .d(wr_data[AW-1:0]), .q(base_q[gi])
    );
  end

  // item progress events
  logic step, period_end;
  assign step       = item_done && en_q;
  assign period_end = step && cnt_last && circ_eff;

  dma_seq_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .wr_prog(cnt_accept), .wr_val(wr_data[CW-1:0]),
    .start(start), .step(step), .circ(circ_eff), .running(en_q),
    .prog(cnt_prog), .live(cnt_live), .last(cnt_last)
  );

  dma_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start(start), .stop_req(stop_req), .step(step), .last(cnt_last),
    .circ_eff(circ_eff), .dbm_eff(dbm_eff),
    .tgt_load(cfg_accept), .tgt_val(wr_data[CFG_CT]),
    .en_q(en_q), .tc_q(tc_q), .target_q(target_q)
  );

  // pointer reload sources
  logic          ptr_load;
  logic [AW-1:0] mem_reload;
  assign ptr_load = start || period_end;
  always_comb begin
    if (start)
      mem_reload = start_target ? base_q[B_MEM1] : base_q[B_MEM0];
    else if (dbm_eff && !target_q)
      mem_reload = base_q[B_MEM1];
    else
      mem_reload = base_q[B_MEM0];
  end

  dma_seq_ptr #(.AW(AW)) u_per_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(base_q[B_PER]),
    .adv(step && pinc), .size_code(psz), .ptr(per_ptr)
  );

  dma_seq_ptr #(.AW(AW)) u_mem_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(mem_reload),
    .adv(step && minc), .size_code(msz), .ptr(mem_ptr)
  );

  // direction routing
  always_comb begin
    case (dir)
      XFER_M2P: begin
        src_addr = mem_ptr;  dst_addr = per_ptr;
        src_size = msz;      dst_size = psz;
      end
      default: begin
        src_addr = per_ptr;  dst_addr = mem_ptr;
        src_size = psz;      dst_size = msz;
      end
    endcase
  end

  // read port
  logic [31:0] cfg_view;
  always_comb begin
    cfg_view         = cfg_q;
    cfg_view[CFG_EN] = en_q;
    cfg_view[CFG_CT] = target_q;
    case (rd_sel)
      SEL_CFG:   rd_data = cfg_view;
      SEL_CNT:   rd_data = 32'(cnt_live);
      SEL_PADDR: rd_data = 32'(base_q[B_PER]);
      SEL_MEM0:  rd_data = 32'(base_q[B_MEM0]);
      SEL_MEM1:  rd_data = 32'(base_q[B_MEM1]);
      SEL_LEFT:  rd_data = bytes_left(32'(cnt_live), psz);
      default:   rd_data = '0;
    endcase
  end

  assign item_req   = en_q;
  assign stream_en  = en_q;
  assign tc_pulse   = tc_q;
  assign cur_target = target_q;

  // R7: configuration cannot change under a running stream
  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> $stable(cfg_q));
  // R7: the active memory base is never rewritten while running
  assert_active_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && $stable(target_q) && !target_q) |-> $stable(base_q[B_MEM0]));
  // R11: a start never happens with an empty programmed count
  assert_no_empty_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> (cnt_live != '0));
endmodule

// File: tb/dma_stream_seq_tb.sv
module dma_stream_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        item_req, item_done = 1'b0;
  logic [31:0] src_addr, dst_addr;
  logic [1:0]  src_size, dst_size;
  logic        tc_pulse, cur_target, stream_en;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_stream_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .item_req(item_req), .item_done(item_done),
    .src_addr(src_addr), .dst_addr(dst_addr), .src_size(src_size), .dst_size(dst_size),
    .tc_pulse(tc_pulse), .cur_target(cur_target), .stream_en(stream_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(int dir, int psz, int msz, bit minc, bit pinc,
                                         bit circ, bit dbm, bit ct, bit en);
    logic [31:0] v = '0;
    v[7:6] = dir[1:0]; v[12:11] = psz[1:0]; v[14:13] = msz[1:0];
    v[10] = minc; v[9] = pinc; v[8] = circ; v[18] = dbm; v[19] = ct; v[0] = en;
    return v;
  endfunction

  function automatic logic [31:0] stride(int code, bit on);
    if (!on) return 32'd0;
    return 32'd1 << ((code > 2) ? 2 : code);
  endfunction

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic item();
    item_done = 1'b1;
    @(negedge clk);
    item_done = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    rd_sel = s; #1; v = rd_data;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = 32'h00C0FFEE;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 en", 32'(stream_en), 0);
    chk("R1 req", 32'(item_req), 0);
    chk("R1 tc", 32'(tc_pulse), 0);
    rd(3'd0, v); chk("R1 cfg", v, 0);
    rd(3'd1, v); chk("R1 cnt", v, 0);

    // R11 start with count 0 ignored
    wr(3'd1, 0);
    wr(3'd0, mk_cfg(0, 0, 0, 1, 0, 0, 0, 0, 1));
    chk("R11 en", 32'(stream_en), 0);
    chk("R11 req", 32'(item_req), 0);

    // R5 circular run, R8 stop
    wr(3'd1, 2); wr(3'd2, 32'h40); wr(3'd3, 32'h100);
    wr(3'd0, mk_cfg(0, 0, 2, 1, 0, 1, 0, 0, 1));
    chk("R2 src", src_addr, 32'h40);
    chk("R2 dst", dst_addr, 32'h100);
    item(); chk("R3 dst step word", dst_addr, 32'h104);
    chk("R3 src fixed", src_addr, 32'h40);
    item();
    chk("R5 tc", 32'(tc_pulse), 1);
    chk("R5 en", 32'(stream_en), 1);
    chk("R5 dst reload", dst_addr, 32'h100);
    rd(3'd1, v); chk("R5 cnt reload", v, 2);
    @(negedge clk); chk("R5 tc drop", 32'(tc_pulse), 0);
    wr(3'd0, mk_cfg(0, 0, 2, 1, 0, 1, 0, 0, 0));
    chk("R8 en held", 32'(stream_en), 1);
    chk("R8 req held", 32'(item_req), 1);
    item();
    chk("R8 en off", 32'(stream_en), 0);
    chk("R8 req off", 32'(item_req), 0);

    // R6 double buffer, R7 write filtering
    wr(3'd1, 2); wr(3'd3, 32'h1000); wr(3'd4, 32'h2000); wr(3'd2, 32'h80);
    wr(3'd0, mk_cfg(1, 2, 0, 1, 0, 0, 1, 0, 1));
    chk("R2 m2p src", src_addr, 32'h1000);
    chk("R2 m2p dst", dst_addr, 32'h80);
    chk("R2 m2p ssize", 32'(src_size), 0);
    chk("R2 m2p dsize", 32'(dst_size), 2);
    chk("R6 tgt0", 32'(cur_target), 0);
    item(); chk("R3 byte step", src_addr, 32'h1001);
    wr(3'd3, 32'h5555); rd(3'd3, v); chk("R7 active base kept", v, 32'h1000);
    wr(3'd4, 32'h2400); rd(3'd4, v); chk("R7 idle base taken", v, 32'h2400);
    item();
    chk("R6 tc", 32'(tc_pulse), 1);
    chk("R6 tgt1", 32'(cur_target), 1);
    chk("R6 src base1", src_addr, 32'h2400);
    wr(3'd3, 32'h3000); rd(3'd3, v); chk("R7 idle base0", v, 32'h3000);
    wr(3'd1, 7); rd(3'd1, v); chk("R7 cnt kept", v, 2);
    wr(3'd2, 32'h99); rd(3'd2, v); chk("R7 paddr kept", v, 32'h80);
    wr(3'd0, mk_cfg(0, 1, 1, 0, 1, 1, 0, 0, 1));
    rd(3'd0, v); chk("R7 cfg kept", v, mk_cfg(1, 2, 0, 1, 0, 0, 1, 1, 1));
    item(); item();
    chk("R6 tgt back", 32'(cur_target), 0);
    chk("R6 src base0", src_addr, 32'h3000);
    wr(3'd0, 0); item();
    chk("R8 dbm stop", 32'(stream_en), 0);

    // R9 remaining bytes
    wr(3'd1, 5); wr(3'd0, mk_cfg(0, 1, 1, 1, 1, 0, 0, 0, 1));
    rd(3'd5, v); chk("R9 left", v, 10);
    item(); rd(3'd5, v); chk("R9 left after", v, 8);
    wr(3'd0, 0); item();
    chk("R8 stop mid", 32'(stream_en), 0);

    // R10 memory to memory ignores double buffer and target
    wr(3'd1, 1); wr(3'd2, 32'h700); wr(3'd3, 32'h800); wr(3'd4, 32'h900);
    wr(3'd0, mk_cfg(2, 2, 2, 1, 1, 0, 1, 1, 1));
    chk("R10 src", src_addr, 32'h700);
    chk("R10 dst", dst_addr, 32'h800);
    item();
    chk("R10 tc", 32'(tc_pulse), 1);
    chk("R10 stop", 32'(stream_en), 0);

    // R4 random normal-mode runs
    for (int it = 0; it < 16; it++) begin
      int dir = int'($urandom % 3);
      int psz = int'($urandom % 3);
      int msz = int'($urandom % 3);
      bit pi = 1'($urandom);
      bit mi = 1'($urandom);
      int cnt = 1 + int'($urandom % 5);
      logic [31:0] pa = $urandom & 32'hFFFF_FFF0;
      logic [31:0] ma = $urandom & 32'hFFFF_FFF0;
      logic [31:0] es, ed;
      wr(3'd1, 32'(cnt)); wr(3'd2, pa); wr(3'd3, ma);
      wr(3'd0, mk_cfg(dir, psz, msz, mi, pi, 0, 0, 0, 1));
      for (int k = 0; k < cnt; k++) begin
        es = (dir == 1) ? ma : pa;
        ed = (dir == 1) ? pa : ma;
        chk("R2 rnd src", src_addr, es);
        chk("R2 rnd dst", dst_addr, ed);
        chk("R2 rnd ssize", 32'(src_size), 32'((dir == 1) ? msz : psz));
        rd(3'd1, v); chk("R4 rnd cnt", v, 32'(cnt - k));
        item();
        pa = pa + stride(psz, pi);
        ma = ma + stride(msz, mi);
      end
      chk("R4 rnd tc", 32'(tc_pulse), 1);
      chk("R4 rnd en", 32'(stream_en), 0);
      @(negedge clk);
      chk("R4 rnd tc drop", 32'(tc_pulse), 0);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule